// File: doc/BRIEF.md
# Write-Back Flush Scheduler for a Two-Line Cache

This block decides when each line of a small write-back cache is written back to main memory. It watches the cache's access stream: valid, read or write, line index, byte offset within the line, and whether the access belongs to a sequential run. From that stream it keeps its own dirty flag for each line. When a line needs writing back, it raises a request on a memory-side port, naming the line. It then waits for a completion acknowledge before it issues another request.

Three triggers cause a write-back. The first is a software request bit per line, set by a pulse and cleared by hardware. The second, when enabled, is a sequential write of the last two byte locations of a line. The third is an inactivity timer per line. This timer counts fixed 240 ns ticks while the line is dirty, and any access to that line restarts it. The tick comes from a free-running prescaler whose divide ratio is derived from the clock period parameter. Software sets the timeout as an 8-bit tick count, and a count of zero turns the timer off.

Top module: `line_wb_sched`

## Requirements
- R1: After synchronous active-low reset, `flush_req_o` is 0, and both `dirty_o` and `man_pend_o` are all zero.
- R2: A write access (`acc_valid_i`=1, `acc_write_i`=1) to line L sets `dirty_o[L]` one clock later. A read access leaves the dirty flag unchanged.
- R3: A pulse on `man_set_i[L]` sets `man_pend_o[L]`. If line L is dirty, `flush_req_o` rises one clock after that with `flush_line_o`=L. The request holds with a stable line index until `flush_ack_i` is seen.
- R4: A software request bit on a clean line clears one clock after it is seen set, and no memory request is issued.
- R5: `flush_ack_i` high while a request is outstanding ends the request at that edge and clears the dirty flag and the software request bit of that line. A write to the same line in that same cycle keeps the line dirty.
- R6: With `auto_en_i`=1, a sequential write (`acc_seq_i`=1) to offset 6 followed by a sequential write to offset 7 as the next access to the same line starts a flush of that line. With `auto_en_i`=0, the same pair causes no flush.
- R7: The offset-7 write causes no automatic flush if the access just before it on that line was not a sequential write to offset 6, or if the offset-7 write is not itself sequential.
- R8: A dirty line whose idle tick count reaches `timeout_i` is flushed. Ticks come every ceil(240000 / `CLK_PERIOD_PS`) clocks, and any read or write to the line restarts its count from zero.
- R9: With `timeout_i`=0, a dirty idle line is never flushed by the timer.
- R10: At most one request is outstanding. When several lines want a flush, the lowest line index is served first.
- R11: `flush_ack_i` while no request is outstanding is ignored: dirty flags and request bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid_i | input | 1 | Cache access in this cycle |
| acc_write_i | input | 1 | Access is a write (1) or a read (0) |
| acc_line_i | input | 1 | Line index of the access |
| acc_off_i | input | 3 | Byte offset inside the line, 0 to 7 |
| acc_seq_i | input | 1 | Access is part of a sequential run |
| man_set_i | input | 2 | Per-line pulse that sets the software flush request bit |
| auto_en_i | input | 1 | Enables the flush on a sequential write that ends a line |
| timeout_i | input | 8 | Idle limit in 240 ns ticks; 0 disables the timer |
| flush_ack_i | input | 1 | Memory side reports the outstanding flush complete |
| flush_req_o | output | 1 | A flush is outstanding |
| flush_line_o | output | 1 | Line being flushed |
| dirty_o | output | 2 | Per-line dirty flags |
| man_pend_o | output | 2 | Per-line software flush request bits, readable by software |

## Verification
A corrupted dirty flag or software request bit reaches `dirty_o` or `man_pend_o` on the next clock. A wrong arbitration choice shows on `flush_req_o` and `flush_line_o` one clock after the trigger. The bench compares these against a behavioural model on every clock, so such faults are caught within a cycle. Timer or prescaler faults stay hidden until a flush request appears early or late. The timed-flush scenarios therefore hold the line idle across a full timeout, and also keep reloading the counter. This catches an early or late request within one tick period.

// File: rtl/wb_sched_pkg.sv
// Package: shared constants and types for the write-back flush scheduler.
// Assumes tick period in picoseconds is fixed at 240 ns.
package wb_sched_pkg;
    localparam int unsigned TICK_PS = 240000;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_t;
endpackage

// File: rtl/wb_tick_gen.sv
// Module: free-running prescaler giving a one-cycle pulse every DIV clocks.
// Assumes DIV >= 2.
module wb_tick_gen #(
    parameter int unsigned DIV = 24
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    // Count 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wb_line_track.sv
// Module: per-line state of one cache line: dirty flag, software request,
// automatic-flush latch, sequential offset tracking and idle tick counter.
// Assumes done_i is a one-cycle pulse when this line's flush completes.
module wb_line_track #(
    parameter int unsigned OFF_W = 3,
    parameter int unsigned TO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             hit_i,
    input  logic             write_i,
    input  logic             seq_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             man_set_i,
    input  logic             auto_en_i,
    input  logic [TO_W-1:0]  timeout_i,
    input  logic             done_i,
    output logic             want_o,
    output logic             dirty_o,
    output logic             man_o
);
    localparam logic [OFF_W-1:0] OFF_LAST = {OFF_W{1'b1}};
    localparam logic [OFF_W-1:0] OFF_PEN  = OFF_LAST - 1'b1;
    localparam logic [TO_W-1:0]  CNT_MAX  = {TO_W{1'b1}};

    logic            dirty_q, man_q, auto_q, pen_q;
    logic [TO_W-1:0] cnt_q;
    logic            wr_hit, auto_fire, idle_hit;

    assign wr_hit    = hit_i & write_i;
    assign auto_fire = wr_hit & seq_i & (off_i == OFF_LAST) & pen_q & auto_en_i;
    assign idle_hit  = (timeout_i != '0) & (cnt_q >= timeout_i);
    assign want_o    = dirty_q & (man_q | auto_q | idle_hit);
    assign dirty_o   = dirty_q;
    assign man_o     = man_q;

    // Dirty flag: set by a write, cleared by completion (write wins).
    always_ff @(posedge clk) begin
        if (!rst_n) dirty_q <= 1'b0;
        else        dirty_q <= (dirty_q & ~done_i) | wr_hit;
    end

    // Software request: dropped on completion or when the line is clean.
    always_ff @(posedge clk) begin
        if (!rst_n) man_q <= 1'b0;
        else        man_q <= (man_q & dirty_q & ~done_i) | man_set_i;
    end

    // Automatic flush latch: held until the flush completes.
    always_ff @(posedge clk) begin
        if (!rst_n) auto_q <= 1'b0;
        else        auto_q <= (auto_q & ~done_i) | auto_fire;
    end

    // Remember whether the last access to this line was a sequential write to the penultimate byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     pen_q <= 1'b0;
        else if (hit_i) pen_q <= wr_hit & seq_i & (off_i == OFF_PEN);
    end

    // Idle counter: cleared while clean, on access or completion; saturating tick count otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (!dirty_q || hit_i || done_i) cnt_q <= '0;
        else if (tick_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wb_flush_arb.sv
// Module: fixed-priority flush issuer. Lowest line index wins; one flush
// outstanding; the request is held until acknowledged.
// Assumes want inputs are stable enough to be sampled once per cycle.
module wb_flush_arb
    import wb_sched_pkg::*;
#(
    parameter int unsigned NUM_LINES = 2,
    parameter int unsigned LW        = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] want_i,
    input  logic                 ack_i,
    output logic                 req_o,
    output logic [LW-1:0]        line_o,
    output logic [NUM_LINES-1:0] done_o
);
    arb_state_t    state_q;
    logic [LW-1:0] line_q;
    logic [LW-1:0] pick;
    logic          any_want;

    // Priority pick of the lowest wanting line.
    always_comb begin
        pick     = '0;
        any_want = 1'b0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (want_i[i]) begin
                pick     = LW'(i);
                any_want = 1'b1;
            end
        end
    end

    // Issue state: start a flush when idle, finish it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            line_q  <= '0;
        end else if (state_q == ARB_BUSY) begin
            if (ack_i) state_q <= ARB_IDLE;
        end else if (any_want) begin
            state_q <= ARB_BUSY;
            line_q  <= pick;
        end
    end

    // Completion strobe decoded per line.
    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_done
            assign done_o[g] = (state_q == ARB_BUSY) & ack_i & (line_q == LW'(g));
        end
    endgenerate

    assign req_o  = (state_q == ARB_BUSY);
    assign line_o = line_q;
endmodule

// File: rtl/line_wb_sched.sv
// Module: top of the write-back flush scheduler. Tracks each line, derives
// the 240 ns tick and issues flushes to the memory side one at a time.
// Assumes CLK_PERIOD_PS divides into a tick ratio of at least 2.
module line_wb_sched
    import wb_sched_pkg::*;
#(
    parameter int unsigned NUM_LINES     = 2,
    parameter int unsigned LINE_BYTES    = 8,
    parameter int unsigned TO_W          = 8,
    parameter int unsigned CLK_PERIOD_PS = 10000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acc_valid_i,
    input  logic                          acc_write_i,
    input  logic [$clog2(NUM_LINES)-1:0]  acc_line_i,
    input  logic [$clog2(LINE_BYTES)-1:0] acc_off_i,
    input  logic                          acc_seq_i,
    input  logic [NUM_LINES-1:0]          man_set_i,
    input  logic                          auto_en_i,
    input  logic [TO_W-1:0]               timeout_i,
    input  logic                          flush_ack_i,
    output logic                          flush_req_o,
    output logic [$clog2(NUM_LINES)-1:0]  flush_line_o,
    output logic [NUM_LINES-1:0]          dirty_o,
    output logic [NUM_LINES-1:0]          man_pend_o
);
    localparam int unsigned LW       = $clog2(NUM_LINES);
    localparam int unsigned OFF_W    = $clog2(LINE_BYTES);
    localparam int unsigned TICK_DIV = (TICK_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

    logic                 tick;
    logic [NUM_LINES-1:0] want, done;

    wb_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            wb_line_track #(.OFF_W(OFF_W), .TO_W(TO_W)) u_line (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick_i    (tick),
                .hit_i     (acc_valid_i && (acc_line_i == LW'(g))),
                .write_i   (acc_write_i),
                .seq_i     (acc_seq_i),
                .off_i     (acc_off_i),
                .man_set_i (man_set_i[g]),
                .auto_en_i (auto_en_i),
                .timeout_i (timeout_i),
                .done_i    (done[g]),
                .want_o    (want[g]),
                .dirty_o   (dirty_o[g]),
                .man_o     (man_pend_o[g])
            );
        end
    endgenerate

    wb_flush_arb #(.NUM_LINES(NUM_LINES), .LW(LW)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .want_i (want),
        .ack_i  (flush_ack_i),
        .req_o  (flush_req_o),
        .line_o (flush_line_o),
        .done_o (done)
    );
endmodule

// File: rtl/line_wb_sched_chk.sv
// Module: property checker for line_wb_sched, bound to every instance.
// Assumes the checker sees the top's ports only.
module line_wb_sched_chk #(
    parameter int unsigned NUM_LINES = 2,
    parameter int unsigned LW        = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 acc_valid_i,
    input logic                 acc_write_i,
    input logic [LW-1:0]        acc_line_i,
    input logic [NUM_LINES-1:0] man_set_i,
    input logic                 flush_ack_i,
    input logic                 flush_req_o,
    input logic [LW-1:0]        flush_line_o,
    input logic [NUM_LINES-1:0] dirty_o,
    input logic [NUM_LINES-1:0] man_pend_o
);
    // R3: an unacknowledged request holds with the same line.
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o && !flush_ack_i |=> flush_req_o && $stable(flush_line_o));

    // R3: a request only ever names a dirty line.
    p_req_dirty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o |-> dirty_o[flush_line_o]);

    // R5: acknowledge ends the request.
    p_ack_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o && flush_ack_i |=> !flush_req_o);

    // R5: acknowledge clears the line's dirty flag unless written in the same cycle.
    p_ack_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o && flush_ack_i &&
        !(acc_valid_i && acc_write_i && acc_line_i == flush_line_o)
        |=> !dirty_o[$past(flush_line_o)]);

    // R11: acknowledge with nothing outstanding keeps dirty flags.
    p_idle_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_req_o && flush_ack_i && !acc_valid_i |=> $stable(dirty_o));

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
            // R4: a request bit on a clean line drops on the next clock.
            p_clean_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
                man_pend_o[g] && !dirty_o[g] && !man_set_i[g] |=> !man_pend_o[g]);
        end
    endgenerate
endmodule

bind line_wb_sched line_wb_sched_chk #(.NUM_LINES(NUM_LINES), .LW($clog2(NUM_LINES))) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid_i  (acc_valid_i),
    .acc_write_i  (acc_write_i),
    .acc_line_i   (acc_line_i),
    .man_set_i    (man_set_i),
    .flush_ack_i  (flush_ack_i),
    .flush_req_o  (flush_req_o),
    .flush_line_o (flush_line_o),
    .dirty_o      (dirty_o),
    .man_pend_o   (man_pend_o)
);

// File: tb/test_line_wb_sched.sv
`timescale 1ns/1ps
module test_line_wb_sched;
    localparam int CLK_NS   = 10;
    localparam int TICK_DIV = 24;   // ceil(240000 / 10000)

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0, acc_write = 1'b0, acc_line = 1'b0, acc_seq = 1'b0;
    logic [2:0] acc_off = '0;
    logic [1:0] man_set = '0;
    logic       auto_en = 1'b0;
    logic [7:0] timeout = '0;
    logic       ack = 1'b0;
    logic       flush_req, flush_line;
    logic [1:0] dirty, man_pend;

    int n_chk = 0, n_fail = 0, cycles = 0;
    bit cmp_on = 1'b0;
    string tag = "R1";

    // Behavioural reference state.
    int m_d[2], m_m[2], m_a[2], m_p[2], m_c[2];
    int m_busy, m_line, m_pc;

    line_wb_sched #(.CLK_PERIOD_PS(CLK_NS * 1000)) i_line_wb_sched (
        .clk(clk), .rst_n(rst_n),
        .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_line_i(acc_line),
        .acc_off_i(acc_off), .acc_seq_i(acc_seq), .man_set_i(man_set),
        .auto_en_i(auto_en), .timeout_i(timeout), .flush_ack_i(ack),
        .flush_req_o(flush_req), .flush_line_o(flush_line),
        .dirty_o(dirty), .man_pend_o(man_pend)
    );

    always #(CLK_NS / 2) clk = ~clk;

    task automatic check(input bit ok, input string r, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    // Reference model: one step per clock, from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < 2; l++) begin
                m_d[l] = 0; m_m[l] = 0; m_a[l] = 0; m_p[l] = 0; m_c[l] = 0;
            end
            m_busy = 0; m_line = 0; m_pc = 0;
        end else begin
            int want[2];
            int tk, done_l;
            tk = (m_pc == TICK_DIV - 1);
            m_pc = tk ? 0 : m_pc + 1;
            for (int l = 0; l < 2; l++)
                want[l] = m_d[l] && (m_m[l] || m_a[l] || (timeout != 0 && m_c[l] >= timeout));
            done_l = (m_busy && ack) ? m_line : -1;
            for (int l = 0; l < 2; l++) begin
                int hit, wr, clr;
                hit = acc_valid && (acc_line == l);
                wr  = hit && acc_write;
                clr = (done_l == l);
                if (!m_d[l] || hit || clr) m_c[l] = 0;
                else if (tk && m_c[l] < 255) m_c[l]++;
                m_a[l] = (m_a[l] && !clr) || (wr && acc_seq && acc_off == 7 && m_p[l] && auto_en);
                if (hit) m_p[l] = wr && acc_seq && acc_off == 6;
                m_m[l] = (m_m[l] && m_d[l] && !clr) || man_set[l];
                m_d[l] = (m_d[l] && !clr) || wr;
            end
            if (m_busy) begin
                if (ack) m_busy = 0;
            end else if (want[0]) begin
                m_busy = 1; m_line = 0;
            end else if (want[1]) begin
                m_busy = 1; m_line = 1;
            end
        end
    end

    // Compare every clock, away from the edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check(flush_req == m_busy, tag, "flush_req", flush_req, m_busy);
            if (m_busy) check(flush_line == m_line, tag, "flush_line", flush_line, m_line);
            for (int l = 0; l < 2; l++) begin
                check(dirty[l] == m_d[l], tag, "dirty", dirty[l], m_d[l]);
                check(man_pend[l] == m_m[l], tag, "man_pend", man_pend[l], m_m[l]);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic access(input bit ln, input bit wr, input int off, input bit seq);
        acc_valid = 1'b1; acc_line = ln; acc_write = wr; acc_off = 3'(off); acc_seq = seq;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_seq = 1'b0;
    endtask

    task automatic pulse_man(input logic [1:0] mask);
        man_set = mask;
        @(negedge clk);
        man_set = '0;
    endtask

    task automatic take_flush(input string r, input int exp_line);
        int w = 0;
        while (!flush_req && w < 20) begin
            @(negedge clk); w++;
        end
        check(flush_req == 1'b1, r, "request seen", flush_req, 1);
        check(flush_line == exp_line, r, "request line", flush_line, exp_line);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check(flush_req == 1'b0, r, "request dropped after ack", flush_req, 0);
        check(dirty[exp_line] == 1'b0, r, "line clean after ack", dirty[exp_line], 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        tag = "R1";
        check(flush_req == 1'b0 && dirty == 2'b00 && man_pend == 2'b00, "R1", "reset state",
              {flush_req, dirty, man_pend}, 0);

        tag = "R2";
        access(0, 0, 2, 0);
        check(dirty[0] == 1'b0, "R2", "read leaves clean", dirty[0], 0);
        access(0, 1, 2, 0);
        check(dirty[0] == 1'b1, "R2", "write sets dirty", dirty[0], 1);

        tag = "R3";
        pulse_man(2'b01);
        check(man_pend[0] == 1'b1, "R3", "request bit set", man_pend[0], 1);
        @(negedge clk);
        check(flush_req == 1'b1 && flush_line == 1'b0, "R3", "request line 0", flush_req, 1);
        idle(5);
        check(flush_req == 1'b1, "R3", "request held without ack", flush_req, 1);
        tag = "R5";
        take_flush("R5", 0);
        check(man_pend[0] == 1'b0, "R5", "request bit cleared", man_pend[0], 0);

        tag = "R4";
        pulse_man(2'b10);
        check(man_pend[1] == 1'b1, "R4", "bit visible once", man_pend[1], 1);
        @(negedge clk);
        check(man_pend[1] == 1'b0 && flush_req == 1'b0, "R4", "clean line bit dropped, no request",
              {man_pend[1], flush_req}, 0);

        tag = "R6";
        auto_en = 1'b0;
        access(1, 1, 6, 1);
        access(1, 1, 7, 1);
        idle(4);
        check(flush_req == 1'b0, "R6", "disabled auto flush", flush_req, 0);
        auto_en = 1'b1;
        access(1, 1, 6, 1);
        access(1, 1, 7, 1);
        take_flush("R6", 1);

        tag = "R7";
        access(1, 1, 5, 1);
        access(1, 1, 7, 1);
        idle(4);
        check(flush_req == 1'b0, "R7", "offset 5 then 7", flush_req, 0);
        access(1, 1, 6, 0);
        access(1, 1, 7, 1);
        idle(4);
        check(flush_req == 1'b0, "R7", "non-sequential 6 then 7", flush_req, 0);
        access(1, 1, 6, 1);
        access(1, 0, 3, 1);
        access(1, 1, 7, 1);
        idle(4);
        check(flush_req == 1'b0, "R7", "read between 6 and 7", flush_req, 0);
        pulse_man(2'b10);
        take_flush("R7", 1);
        auto_en = 1'b0;

        tag = "R8";
        timeout = 8'd3;
        access(0, 1, 1, 0);
        for (int k = 0; k < 12; k++) begin
            idle(TICK_DIV);
            access(0, 0, 4, 0);
        end
        check(flush_req == 1'b0, "R8", "reloaded counter, no flush", flush_req, 0);
        idle(2 * TICK_DIV);
        check(flush_req == 1'b0, "R8", "below limit", flush_req, 0);
        take_flush("R8", 0);

        tag = "R9";
        timeout = 8'd0;
        access(1, 1, 0, 0);
        idle(300 * TICK_DIV);
        check(flush_req == 1'b0 && dirty[1] == 1'b1, "R9", "timer disabled", flush_req, 0);
        timeout = 8'd1;
        take_flush("R9", 1);
        timeout = 8'd0;

        tag = "R10";
        access(0, 1, 0, 0);
        access(1, 1, 0, 0);
        pulse_man(2'b11);
        @(negedge clk);
        check(flush_req == 1'b1 && flush_line == 1'b0, "R10", "line 0 first", flush_line, 0);
        idle(3);
        check(flush_line == 1'b0, "R10", "one outstanding", flush_line, 0);
        take_flush("R10", 0);
        take_flush("R10", 1);

        tag = "R11";
        access(0, 1, 3, 0);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check(dirty[0] == 1'b1 && flush_req == 1'b0, "R11", "idle ack ignored", dirty[0], 1);
        pulse_man(2'b01);
        take_flush("R11", 0);

        tag = "R5";
        access(1, 1, 2, 0);
        pulse_man(2'b10);
        @(negedge clk);
        acc_valid = 1'b1; acc_line = 1'b1; acc_write = 1'b1; acc_off = 3'd0; acc_seq = 1'b0;
        ack = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; ack = 1'b0;
        check(dirty[1] == 1'b1 && flush_req == 1'b0, "R5", "write in ack cycle keeps dirty", dirty[1], 1);

        idle(4);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule